// File: doc/BRIEF.md
# Four-Way Peripheral Pin Multiplexer

This block sits between a bank of I/O pads and the logic that may drive them. Every pin is owned either by the general-purpose I/O logic or by one of four internal peripheral functions. Ownership is changed through a pair of write-only mask registers. One mask hands pins to their peripheral and the other returns them to GPIO. A status register shows who currently owns each pin.

The peripheral function of a pin is chosen by one bit from each of two ordinary read/write select registers. Software changes one pin with a read-mask-write sequence, so the other pins keep their selection. The block routes the matching pad output value and pad output enable to each pad. Pad electrical behaviour and the peripherals themselves are not part of the block.

Top module: `pinmux_bank`

## Requirements
- R1: After reset every pin is GPIO-owned (status all ones), both select registers and the GPIO data and enable registers read zero, and every pad_oe bit is 0.
- R2: A write to word address 1 (peripheral handoff) makes each pin whose mask bit is 1 peripheral-owned. Pins whose mask bit is 0 keep their ownership.
- R3: A write to word address 0 (GPIO return) makes each pin whose mask bit is 1 GPIO-owned. Pins whose mask bit is 0 keep their ownership.
- R4: Word address 2 reads 1 in each bit whose pin is GPIO-owned and 0 in each bit whose pin is peripheral-owned. Writes to this address have no effect.
- R5: Word addresses 3 (select low) and 4 (select high) are full-width read/write registers. For pin p the function code is {high[p], low[p]}: 00 is function A, 01 is B, 10 is C and 11 is D.
- R6: For a peripheral-owned pin p with function code f, pad_out[p] equals fn_out[f*NUM_PINS+p] and pad_oe[p] equals fn_oe[f*NUM_PINS+p].
- R7: For a GPIO-owned pin p, pad_out[p] and pad_oe[p] follow bit p of the GPIO data register (word 5) and the GPIO enable register (word 6). The select registers and the peripheral lines have no effect on that pin.
- R8: Reads of the write-only addresses 0 and 1, and of any unmapped address, return zero.
- R9: A register write takes effect at the clock edge that accepts it. Before that edge the pads keep their old routing, and from that edge on they use the new routing. Read data is combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | NUM_PINS | Write data or pin mask |
| bus_rdata | output | NUM_PINS | Combinational read data |
| fn_out | input | 4*NUM_PINS | Peripheral output lines, function f of pin p at bit f*NUM_PINS+p |
| fn_oe | input | 4*NUM_PINS | Peripheral output enables, same layout as fn_out |
| pad_out | output | NUM_PINS | Pad output value |
| pad_oe | output | NUM_PINS | Pad output enable |

## Verification
The bench builds the bank with NUM_PINS set to 8 and ADDR_W left at 3. With 8 pins, the four function slices fill a single 32-bit peripheral vector, so every pin can be checked against every code in one pass. The 3-bit address also leaves an unmapped word, 7, which is reachable for the zero-read case. The mixed mask patterns give some pins each of the four codes at the same time and keep GPIO-owned and peripheral-owned pins side by side. This exposes any leakage between routing paths.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int NUM_FUNCS   = 4;
  localparam int REG_IO_ON   = 0;
  localparam int REG_IO_OFF  = 1;
  localparam int REG_OWN     = 2;
  localparam int REG_SEL_LO  = 3;
  localparam int REG_SEL_HI  = 4;
  localparam int REG_GP_OUT  = 5;
  localparam int REG_GP_OE   = 6;

  typedef enum logic [1:0] {
    FN_A = 2'b00,
    FN_B = 2'b01,
    FN_C = 2'b10,
    FN_D = 2'b11
  } fn_code_e;

  // Combine the two select-register bits of one pin into a function code.
  function automatic fn_code_e fn_code(input logic hi, input logic lo);
    return fn_code_e'({hi, lo});
  endfunction
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  output logic [NUM_PINS-1:0] own_gpio,
  output logic [NUM_PINS-1:0] sel_lo,
  output logic [NUM_PINS-1:0] sel_hi,
  output logic [NUM_PINS-1:0] gp_out,
  output logic [NUM_PINS-1:0] gp_oe
);
  // Decoded write strobes, kept as named wires for the assertions.
  logic wr_on, wr_off, wr_sel_lo, wr_sel_hi, wr_gp_out, wr_gp_oe;
  assign wr_on     = bus_wr && (bus_addr == ADDR_W'(REG_IO_ON));
  assign wr_off    = bus_wr && (bus_addr == ADDR_W'(REG_IO_OFF));
  assign wr_sel_lo = bus_wr && (bus_addr == ADDR_W'(REG_SEL_LO));
  assign wr_sel_hi = bus_wr && (bus_addr == ADDR_W'(REG_SEL_HI));
  assign wr_gp_out = bus_wr && (bus_addr == ADDR_W'(REG_GP_OUT));
  assign wr_gp_oe  = bus_wr && (bus_addr == ADDR_W'(REG_GP_OE));

  logic [NUM_PINS-1:0] own_q, sel_lo_q, sel_hi_q, gp_out_q, gp_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= '1;
      sel_lo_q <= '0;
      sel_hi_q <= '0;
      gp_out_q <= '0;
      gp_oe_q  <= '0;
    end else begin
      if (wr_on)     own_q    <= own_q | bus_wdata;
      if (wr_off)    own_q    <= own_q & ~bus_wdata;
      if (wr_sel_lo) sel_lo_q <= bus_wdata;
      if (wr_sel_hi) sel_hi_q <= bus_wdata;
      if (wr_gp_out) gp_out_q <= bus_wdata;
      if (wr_gp_oe)  gp_oe_q  <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(REG_OWN))         bus_rdata = own_q;
    else if (bus_addr == ADDR_W'(REG_SEL_LO)) bus_rdata = sel_lo_q;
    else if (bus_addr == ADDR_W'(REG_SEL_HI)) bus_rdata = sel_hi_q;
    else if (bus_addr == ADDR_W'(REG_GP_OUT)) bus_rdata = gp_out_q;
    else if (bus_addr == ADDR_W'(REG_GP_OE))  bus_rdata = gp_oe_q;
  end

  assign own_gpio = own_q;
  assign sel_lo   = sel_lo_q;
  assign sel_hi   = sel_hi_q;
  assign gp_out   = gp_out_q;
  assign gp_oe    = gp_oe_q;

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (own_q == '1 && sel_lo_q == '0 && sel_hi_q == '0 && gp_oe_q == '0)); // R1
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) wr_off |=> ((own_q & $past(bus_wdata)) == '0)); // R2
  AST_OFF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) wr_off |=> (((own_q ^ $past(own_q)) & ~$past(bus_wdata)) == '0)); // R2
  AST_ON_SETS: assert property (@(posedge clk) disable iff (!rst_n) wr_on |=> ((own_q & $past(bus_wdata)) == $past(bus_wdata))); // R3
  AST_ON_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) wr_on |=> (((own_q ^ $past(own_q)) & ~$past(bus_wdata)) == '0)); // R3
  AST_OWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(wr_on || wr_off) |=> $stable(own_q)); // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(wr_sel_lo || wr_sel_hi) |=> ($stable(sel_lo_q) && $stable(sel_hi_q))); // R5
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route
  import pinmux_pkg::*;
(
  input  logic                 own_gpio,
  input  logic                 sel_lo,
  input  logic                 sel_hi,
  input  logic                 gp_out,
  input  logic                 gp_oe,
  input  logic [NUM_FUNCS-1:0] fn_out,
  input  logic [NUM_FUNCS-1:0] fn_oe,
  output logic                 pad_out,
  output logic                 pad_oe
);
  fn_code_e code;
  logic     per_out, per_oe;

  assign code = fn_code(sel_hi, sel_lo);

  always_comb begin
    unique case (code)
      FN_A:    begin per_out = fn_out[0]; per_oe = fn_oe[0]; end
      FN_B:    begin per_out = fn_out[1]; per_oe = fn_oe[1]; end
      FN_C:    begin per_out = fn_out[2]; per_oe = fn_oe[2]; end
      default: begin per_out = fn_out[3]; per_oe = fn_oe[3]; end
    endcase
  end

  assign pad_out = own_gpio ? gp_out : per_out;
  assign pad_oe  = own_gpio ? gp_oe  : per_oe;
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [NUM_PINS-1:0]           bus_wdata,
  output logic [NUM_PINS-1:0]           bus_rdata,
  input  logic [NUM_FUNCS*NUM_PINS-1:0] fn_out,
  input  logic [NUM_FUNCS*NUM_PINS-1:0] fn_oe,
  output logic [NUM_PINS-1:0]           pad_out,
  output logic [NUM_PINS-1:0]           pad_oe
);
  logic [NUM_PINS-1:0] own_gpio, sel_lo, sel_hi, gp_out, gp_oe;

  pinmux_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .own_gpio(own_gpio),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .gp_out(gp_out), .gp_oe(gp_oe)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_FUNCS-1:0] pin_fo, pin_fe;
    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
      assign pin_fo[f] = fn_out[f*NUM_PINS+p];
      assign pin_fe[f] = fn_oe[f*NUM_PINS+p];
    end
    pinmux_route u_route (
      .own_gpio(own_gpio[p]), .sel_lo(sel_lo[p]), .sel_hi(sel_hi[p]),
      .gp_out(gp_out[p]), .gp_oe(gp_oe[p]), .fn_out(pin_fo), .fn_oe(pin_fe),
      .pad_out(pad_out[p]), .pad_oe(pad_oe[p])
    );
  end

  AST_GPIO_PADS: assert property (@(posedge clk) disable iff (!rst_n) ((own_gpio == '1) && $stable(gp_out) && $stable(gp_oe) && $stable(own_gpio)) |-> ($stable(pad_out) && $stable(pad_oe))); // R7
  AST_RESET_PADS: assert property (@(posedge clk) !rst_n |=> (pad_oe == '0)); // R1
endmodule

// File: tb/pinmux_bank_test.sv
module pinmux_bank_test;
  localparam int N  = 8;
  localparam int AW = 3;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           bus_wr = 0;
  logic [AW-1:0]  bus_addr = '0;
  logic [N-1:0]   bus_wdata = '0;
  logic [N-1:0]   bus_rdata;
  logic [4*N-1:0] fn_out = '0;
  logic [4*N-1:0] fn_oe = '0;
  logic [N-1:0]   pad_out, pad_oe;

  pinmux_bank #(.NUM_PINS(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fn_out(fn_out),
    .fn_oe(fn_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  logic [N-1:0] m_own = '1, m_lo = '0, m_hi = '0, m_dout = '0, m_doe = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_pad(input logic [4*N-1:0] fv, input logic [N-1:0] gv);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) begin
      if (m_own[p]) r[p] = gv[p];
      else case ({m_hi[p], m_lo[p]})
        2'b00: r[p] = fv[p];
        2'b01: r[p] = fv[N+p];
        2'b10: r[p] = fv[2*N+p];
        default: r[p] = fv[3*N+p];
      endcase
    end
    return r;
  endfunction

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 0;
    case (a)
      0: m_own = m_own | d;
      1: m_own = m_own & ~d;
      3: m_lo = d;
      4: m_hi = d;
      5: m_dout = d;
      6: m_doe = d;
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [N-1:0] d);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic check_pads(input string req);
    check(req, 32'(pad_out), 32'(exp_pad(fn_out, m_dout)));
    check(req, 32'(pad_oe), 32'(exp_pad(fn_oe, m_doe)));
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    rd(2, d); check("R1 own", 32'(d), 32'hFF);
    rd(3, d); check("R1 sel_lo", 32'(d), 0);
    rd(4, d); check("R1 sel_hi", 32'(d), 0);
    rd(5, d); check("R1 gp_out", 32'(d), 0);
    rd(6, d); check("R1 gp_oe", 32'(d), 0);
    check("R1 pad_oe", 32'(pad_oe), 0);
  endtask

  task automatic t_sel_rw();
    logic [N-1:0] d;
    wr(3, 8'hA5); wr(4, 8'h3C);
    rd(3, d); check("R5 lo", 32'(d), 32'hA5);
    rd(4, d); check("R5 hi", 32'(d), 32'h3C);
    rd(3, d); wr(3, d | 8'h02);
    rd(3, d); check("R5 rmw", 32'(d), 32'hA7);
    wr(2, 8'h00);
    rd(2, d); check("R4 ro", 32'(d), 32'hFF);
  endtask

  task automatic t_handoff();
    logic [N-1:0] d;
    fn_out = 32'hC3A5_5A3C; fn_oe = 32'h0FF0_33CC;
    wr(5, 8'h96); wr(6, 8'h5A);
    wr(1, 8'h0F);
    rd(2, d); check("R2 off", 32'(d), 32'hF0);
    wr(1, 8'h00);
    rd(2, d); check("R2 zero mask", 32'(d), 32'hF0);
    check_pads("R6 mixed");
    wr(1, 8'hF0);
    rd(2, d); check("R4 all periph", 32'(d), 0);
    check_pads("R6 all");
  endtask

  task automatic t_codes();
    for (int c = 0; c < 4; c++) begin
      wr(3, c[0] ? 8'hFF : 8'h00);
      wr(4, c[1] ? 8'hFF : 8'h00);
      check("R5 code out", 32'(pad_out), 32'(fn_out[c*N +: N]));
      check("R6 code oe", 32'(pad_oe), 32'(fn_oe[c*N +: N]));
    end
    wr(3, 8'hCC); wr(4, 8'hF0);
    check_pads("R6 per-pin codes");
    fn_out = ~fn_out; fn_oe = fn_oe ^ 32'h1234_5678;
    #1 check_pads("R6 live lines");
  endtask

  task automatic t_return();
    logic [N-1:0] d;
    wr(0, 8'h05);
    rd(2, d); check("R3 on", 32'(d), 32'h05);
    wr(0, 8'h00);
    rd(2, d); check("R3 zero mask", 32'(d), 32'h05);
    check_pads("R7 mixed");
  endtask

  task automatic t_gpio();
    logic [N-1:0] po, pe;
    wr(0, 8'hFF);
    check("R7 out", 32'(pad_out), 32'h96);
    check("R7 oe", 32'(pad_oe), 32'h5A);
    po = pad_out; pe = pad_oe;
    wr(3, 8'h3F); wr(4, 8'hE1);
    fn_out = 32'hFFFF_0000; fn_oe = 32'h00FF_FF00;
    #1 check("R7 sel ignored out", 32'(pad_out), 32'(po));
    check("R7 sel ignored oe", 32'(pad_oe), 32'(pe));
  endtask

  task automatic t_wo_read();
    logic [N-1:0] d;
    rd(0, d); check("R8 addr0", 32'(d), 0);
    rd(1, d); check("R8 addr1", 32'(d), 0);
    rd(7, d); check("R8 addr7", 32'(d), 0);
  endtask

  task automatic t_timing();
    @(negedge clk);
    bus_wr = 1; bus_addr = AW'(1); bus_wdata = 8'h80;
    #1 check("R9 before edge", 32'(pad_oe), 32'(exp_pad(fn_oe, m_doe)));
    @(posedge clk);
    #1 bus_wr = 0;
    m_own = m_own & ~8'h80;
    check("R9 after edge oe", 32'(pad_oe), 32'(exp_pad(fn_oe, m_doe)));
    check("R9 after edge out", 32'(pad_out), 32'(exp_pad(fn_out, m_dout)));
  endtask

  initial begin : watchdog
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sel_rw();
    t_handoff();
    t_codes();
    t_return();
    t_gpio();
    t_wo_read();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule